// File: doc/BRIEF.md
# Four-Channel DMA Transfer Engine

This block moves data between memory and peripherals without processor involvement, on four channels. A processor programs each channel through a small register port while it still owns the bus. Each channel has a start address and a 16-bit count word. The top two bits of the count word choose the kind of transfer. The low fourteen bits hold the number of transfers minus one. The processor then sets the channel's enable bit in the mode register.

When an enabled channel's peripheral raises its request line, the engine asks the processor for the bus. It waits for the grant, then performs one transfer per service slot. A fixed-priority pick is made again before every slot. In each transfer the engine acknowledges the selected peripheral and presents the address in three parts. It drives the memory and I/O strobes that match the transfer kind, and flags the final transfer of a block.

Each channel stops itself at terminal count, apart from one reload channel. With chaining turned on, that channel refills its address and count from a companion channel and keeps running. A periodic marker output flags every 128th transfer of a block.

Top module: `dma4_engine`

## Requirements
- R1: After reset, hrq, dack, every strobe, tc, mark and a_hi_stb are low. The status register (select 8) and the mode register (select 9) both read as zero.
- R2: A register write with cpu_sel = 2k loads channel k's address, and cpu_sel = 2k+1 loads its count word. The count word holds the transfer kind in bits 15:14 and the transfer count minus one in bits 13:0. A write to select 8 loads the mode register: bits 3:0 enable channels 0 to 3, and bit 7 turns on chaining. Reads of selects 0 to 7 and of select 9 return the current register values.
- R3: An enabled channel whose request is high raises hrq on the next cycle. No dack appears until hlda is seen high. hrq falls once no enabled channel is requesting.
- R4: A request on a channel whose enable bit is clear has no effect: hrq and dack stay low.
- R5: A count field of N-1 gives exactly N transfers, at addresses from the start address upward in steps of one. tc is high only on the last of them, after which the channel's enable bit reads back as clear.
- R6: During a transfer exactly one dack bit is high. Kind 2'b10 (read) drives mem_rd and io_wr. Kind 2'b01 (write) drives io_rd and mem_wr. Kind 2'b00 (verify) drives no strobe.
- R7: During each transfer a_lo carries address bits 3:0, a_mid carries bits 7:4 and a_hi carries bits 15:8, with a_hi_stb high.
- R8: Channel 0 has the highest priority and channel 3 the lowest. The winner is chosen again before every transfer, so a higher-priority request that arrives in the middle of a block is served before the rest of that block.
- R9: Reading select 8 returns one terminal-count flag per channel in bits 3:0 and the update flag in bit 4. The read clears the terminal-count flags.
- R10: With chaining on, channel 2 at terminal count loads channel 3's address and count word and stays enabled. The update flag is set at that reload and clears on the next channel 2 transfer.
- R11: mark is high on the 128th, 256th, ... transfer after a channel's count word is written or reloaded.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cpu_wr | input | 1 | Register write strobe |
| cpu_rd | input | 1 | Register read strobe |
| cpu_sel | input | 4 | Register select |
| cpu_wdata | input | 16 | Register write data |
| cpu_rdata | output | 16 | Register read data (zero when cpu_rd is low) |
| drq | input | 4 | Peripheral transfer requests |
| dack | output | 4 | Peripheral acknowledges, one-hot during a transfer |
| hrq | output | 1 | Bus request to the processor |
| hlda | input | 1 | Bus grant from the processor |
| a_lo | output | 4 | Address bits 3:0 during a transfer |
| a_mid | output | 4 | Address bits 7:4 during a transfer |
| a_hi | output | 8 | Address bits 15:8 during a transfer, for external latching |
| a_hi_stb | output | 1 | Latch strobe for a_hi |
| mem_rd | output | 1 | Memory read strobe |
| mem_wr | output | 1 | Memory write strobe |
| io_rd | output | 1 | Peripheral read strobe |
| io_wr | output | 1 | Peripheral write strobe |
| tc | output | 1 | Last transfer of a block |
| mark | output | 1 | Every 128th transfer of a block |

## Verification
The assertions assume that hlda rises only in answer to hrq and stays high for as long as hrq is held. They also assume that the processor leaves the registers alone while it has granted the bus. The bench's processor stub copies hrq into hlda one cycle later. The bench also issues register accesses only after hold has been released for several cycles. Each peripheral keeps its request high until the bench has counted the acknowledges it wants, so that no block is cut short by a request dropping part-way through.

// File: rtl/dma_pkg.sv
package dma_pkg;

    typedef enum logic [1:0] {
        OP_VERIFY = 2'b00,
        OP_WRITE  = 2'b01,
        OP_READ   = 2'b10,
        OP_RSVD   = 2'b11
    } op_e;

    typedef enum logic [1:0] {
        S_IDLE,
        S_WAIT,
        S_XFER
    } st_e;

    typedef struct packed {
        logic mem_rd;
        logic mem_wr;
        logic io_rd;
        logic io_wr;
    } strobe_t;

    function automatic strobe_t op_strobes(op_e op);
        strobe_t s;
        s = '0;
        case (op)
            OP_READ:  begin s.mem_rd = 1'b1; s.io_wr = 1'b1; end
            OP_WRITE: begin s.io_rd  = 1'b1; s.mem_wr = 1'b1; end
            default:  s = '0;
        endcase
        return s;
    endfunction

endpackage

// File: rtl/dma_prio_arb.sv
module dma_prio_arb #(
    parameter int N = 4,
    localparam int IW = (N > 1) ? $clog2(N) : 1
) (
    input  logic [N-1:0]  req,
    output logic [IW-1:0] idx,
    output logic          any
);

    always_comb begin
        idx = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (req[i]) idx = IW'(i);
        end
        any = |req;
    end

    // R8
    always_comb begin
        if (any) begin
            winner_req_chk: assert (req[idx]);
        end
    end

endmodule

// File: rtl/dma_chan_regs.sv
module dma_chan_regs #(
    parameter int AW = 16,
    parameter int CW = 14,
    parameter int MARK_PERIOD = 128,
    localparam int MKW = $clog2(MARK_PERIOD)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          wr_addr,
    input  logic          wr_cnt,
    input  logic [AW-1:0] wdata,
    input  logic          step,
    input  logic          reload,
    input  logic [AW-1:0] src_addr,
    input  logic [CW+1:0] src_cnt,
    output logic [AW-1:0] addr,
    output logic [CW+1:0] cnt,
    output logic          last,
    output logic          mark_hit
);

    logic [MKW-1:0] mk;

    assign last     = (cnt[CW-1:0] == '0);
    assign mark_hit = (mk == MKW'(MARK_PERIOD - 1));

    always_ff @(posedge clk) begin
        if (rst) begin
            addr <= '0;
            cnt  <= '0;
            mk   <= '0;
        end else if (step) begin
            if (reload && last) begin
                addr <= src_addr;
                cnt  <= src_cnt;
                mk   <= '0;
            end else begin
                addr <= addr + 1'b1;
                mk   <= mk + 1'b1;
                if (!last) cnt[CW-1:0] <= cnt[CW-1:0] - 1'b1;
            end
        end else begin
            if (wr_addr) addr <= wdata;
            if (wr_cnt) begin
                cnt <= wdata[CW+1:0];
                mk  <= '0;
            end
        end
    end

    // R5
    addr_step_chk: assert property (@(posedge clk) disable iff (rst)
        (step && !(reload && last)) |=> (addr == $past(addr) + 1'b1));

    // R5
    cnt_dec_chk: assert property (@(posedge clk) disable iff (rst)
        (step && !last) |=> (cnt[CW-1:0] == $past(cnt[CW-1:0]) - 1'b1));

endmodule

// File: rtl/dma4_engine.sv
module dma4_engine
    import dma_pkg::*;
#(
    parameter int NCH = 4,
    parameter int AW = 16,
    parameter int CW = 14,
    parameter int MARK_PERIOD = 128,
    parameter int AUTO_CH = 2,
    parameter int AUTO_SRC = 3,
    localparam int SELW = $clog2(2 * NCH + 2),
    localparam int IDXW = $clog2(NCH)
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            cpu_wr,
    input  logic            cpu_rd,
    input  logic [SELW-1:0] cpu_sel,
    input  logic [AW-1:0]   cpu_wdata,
    output logic [AW-1:0]   cpu_rdata,
    input  logic [NCH-1:0]  drq,
    output logic [NCH-1:0]  dack,
    output logic            hrq,
    input  logic            hlda,
    output logic [3:0]      a_lo,
    output logic [3:0]      a_mid,
    output logic [AW-9:0]   a_hi,
    output logic            a_hi_stb,
    output logic            mem_rd,
    output logic            mem_wr,
    output logic            io_rd,
    output logic            io_wr,
    output logic            tc,
    output logic            mark
);

    localparam logic [SELW-1:0] SEL_MODE = SELW'(2 * NCH);
    localparam logic [SELW-1:0] SEL_MRD  = SELW'(2 * NCH + 1);
    localparam logic [IDXW-1:0] AUTO_IDX = IDXW'(AUTO_CH);

    st_e             state;
    logic [IDXW-1:0] cur;
    logic [NCH-1:0]  en;
    logic            auto_en;
    logic [NCH-1:0]  tc_sts;
    logic            upd;

    logic [AW-1:0]   ch_addr [NCH];
    logic [CW+1:0]   ch_cnt  [NCH];
    logic [NCH-1:0]  ch_last;
    logic [NCH-1:0]  ch_mark;
    logic [IDXW-1:0] win_idx;
    logic            any_req;
    logic            xfer;
    logic            slave_ok;
    strobe_t         stb;

    assign xfer     = (state == S_XFER);
    assign slave_ok = !hlda;

    dma_prio_arb #(.N(NCH)) arb_i (
        .req (drq & en),
        .idx (win_idx),
        .any (any_req)
    );

    for (genvar k = 0; k < NCH; k++) begin : g_ch
        dma_chan_regs #(.AW(AW), .CW(CW), .MARK_PERIOD(MARK_PERIOD)) regs_i (
            .clk      (clk),
            .rst      (rst),
            .wr_addr  (cpu_wr && slave_ok && cpu_sel == SELW'(2 * k)),
            .wr_cnt   (cpu_wr && slave_ok && cpu_sel == SELW'(2 * k + 1)),
            .wdata    (cpu_wdata),
            .step     (xfer && cur == IDXW'(k)),
            .reload   (auto_en && k == AUTO_CH),
            .src_addr (ch_addr[AUTO_SRC]),
            .src_cnt  (ch_cnt[AUTO_SRC]),
            .addr     (ch_addr[k]),
            .cnt      (ch_cnt[k]),
            .last     (ch_last[k]),
            .mark_hit (ch_mark[k])
        );
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state   <= S_IDLE;
            cur     <= '0;
            en      <= '0;
            auto_en <= 1'b0;
            tc_sts  <= '0;
            upd     <= 1'b0;
        end else begin
            case (state)
                S_IDLE: if (any_req) state <= S_WAIT;
                S_WAIT: begin
                    if (!any_req) state <= S_IDLE;
                    else if (hlda) begin
                        cur   <= win_idx;
                        state <= S_XFER;
                    end
                end
                default: state <= S_WAIT;
            endcase
            if (cpu_wr && slave_ok && cpu_sel == SEL_MODE) begin
                en      <= cpu_wdata[NCH-1:0];
                auto_en <= cpu_wdata[7];
            end
            if (cpu_rd && slave_ok && cpu_sel == SEL_MODE) tc_sts <= '0;
            if (xfer) begin
                if (cur == AUTO_IDX) upd <= 1'b0;
                if (ch_last[cur]) begin
                    tc_sts[cur] <= 1'b1;
                    if (auto_en && cur == AUTO_IDX) upd <= 1'b1;
                    else en[cur] <= 1'b0;
                end
            end
        end
    end

    always_comb begin
        hrq = xfer || (state == S_WAIT && any_req);
        dack = '0;
        if (xfer) dack[cur] = 1'b1;
        stb = xfer ? op_strobes(op_e'(ch_cnt[cur][CW+1:CW])) : '0;
        mem_rd = stb.mem_rd;
        mem_wr = stb.mem_wr;
        io_rd  = stb.io_rd;
        io_wr  = stb.io_wr;
        tc     = xfer && ch_last[cur];
        mark   = xfer && ch_mark[cur];
        a_hi_stb = xfer;
        a_lo  = xfer ? ch_addr[cur][3:0] : '0;
        a_mid = xfer ? ch_addr[cur][7:4] : '0;
        a_hi  = xfer ? ch_addr[cur][AW-1:8] : '0;
    end

    always_comb begin
        cpu_rdata = '0;
        if (cpu_rd) begin
            for (int k = 0; k < NCH; k++) begin
                if (cpu_sel == SELW'(2 * k))     cpu_rdata = ch_addr[k];
                if (cpu_sel == SELW'(2 * k + 1)) cpu_rdata = AW'(ch_cnt[k]);
            end
            if (cpu_sel == SEL_MODE) begin
                cpu_rdata[NCH-1:0] = tc_sts;
                cpu_rdata[NCH]     = upd;
            end
            if (cpu_sel == SEL_MRD) begin
                cpu_rdata[NCH-1:0] = en;
                cpu_rdata[7]       = auto_en;
            end
        end
    end

    // R3
    dack_needs_hlda_chk: assert property (@(posedge clk) disable iff (rst)
        (dack != '0) |-> hlda);

    // R3
    hrq_cause_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(hrq) |-> $past(|(drq & en)));

    // R6
    dack_onehot_chk: assert property (@(posedge clk) disable iff (rst)
        $onehot0(dack));

    // R6
    strobe_excl_chk: assert property (@(posedge clk) disable iff (rst)
        !(mem_rd && mem_wr) && !(io_rd && io_wr) && !(mem_rd && io_rd));

    // R5
    tc_stop_chk: assert property (@(posedge clk) disable iff (rst)
        (tc && !(auto_en && cur == AUTO_IDX)) |=> !en[$past(cur)]);

    // R10
    chain_keep_chk: assert property (@(posedge clk) disable iff (rst)
        (tc && auto_en && cur == AUTO_IDX) |=> (upd && en[AUTO_CH]));

endmodule

// File: tb/dma4_engine_tb_top.sv
`timescale 1ns/1ps
module dma4_engine_tb_top;

    typedef struct packed {
        logic [1:0]  ch;
        logic [15:0] addr;
        logic [1:0]  op;
        logic        tc;
        logic        mk;
    } exp_t;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cpu_wr = 1'b0;
    logic        cpu_rd = 1'b0;
    logic [3:0]  cpu_sel = '0;
    logic [15:0] cpu_wdata = '0;
    logic [15:0] cpu_rdata;
    logic [3:0]  drq = '0;
    logic [3:0]  dack;
    logic        hrq;
    logic        hlda = 1'b0;
    logic [3:0]  a_lo, a_mid;
    logic [7:0]  a_hi;
    logic        a_hi_stb, mem_rd, mem_wr, io_rd, io_wr, tc, mark;

    int   n_chk = 0;
    int   n_fail = 0;
    exp_t exp_q[$];

    always #10 clk = ~clk;

    // processor stub: grants the bus one cycle after the request
    always @(posedge clk) hlda <= rst ? 1'b0 : hrq;

    dma4_engine dut_i (
        .clk(clk), .rst(rst), .cpu_wr(cpu_wr), .cpu_rd(cpu_rd), .cpu_sel(cpu_sel),
        .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata), .drq(drq), .dack(dack),
        .hrq(hrq), .hlda(hlda), .a_lo(a_lo), .a_mid(a_mid), .a_hi(a_hi),
        .a_hi_stb(a_hi_stb), .mem_rd(mem_rd), .mem_wr(mem_wr), .io_rd(io_rd),
        .io_wr(io_wr), .tc(tc), .mark(mark)
    );

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic reg_write(input logic [3:0] sel, input logic [15:0] d);
        @(negedge clk);
        cpu_sel = sel; cpu_wdata = d; cpu_wr = 1'b1;
        @(negedge clk);
        cpu_wr = 1'b0;
    endtask

    task automatic reg_check(input logic [3:0] sel, input logic [15:0] e, input string req);
        @(negedge clk);
        cpu_sel = sel; cpu_rd = 1'b1;
        #1;
        chk(cpu_rdata == e, req, 32'(cpu_rdata), 32'(e));
        @(negedge clk);
        cpu_rd = 1'b0;
    endtask

    task automatic push_item(input int ch, input int addr, input int op, input bit t, input bit m);
        exp_t e;
        e.ch = 2'(ch); e.addr = 16'(addr); e.op = 2'(op); e.tc = t; e.mk = m;
        exp_q.push_back(e);
    endtask

    task automatic push_block(input int ch, input int addr, input int n, input int op);
        for (int i = 0; i < n; i++)
            push_item(ch, addr + i, op, i == n - 1, ((i + 1) % 128) == 0);
    endtask

    task automatic drain();
        while (exp_q.size() != 0) @(negedge clk);
        repeat (3) @(negedge clk);
    endtask

    // monitor: pops one expected transfer per acknowledge
    always @(negedge clk) begin
        if (!rst && dack != '0) begin
            if (exp_q.size() == 0) begin
                chk(1'b0, "R5 unexpected transfer", 32'(dack), 32'h0);
            end else begin
                exp_t e;
                logic [3:0] es;
                e = exp_q.pop_front();
                es = (e.op == 2'b10) ? 4'b1001 : (e.op == 2'b01) ? 4'b0110 : 4'b0000;
                chk(dack == (4'b1 << e.ch), "R8 dack/priority", 32'(dack), 32'(4'b1 << e.ch));
                chk({a_hi, a_mid, a_lo} == e.addr && a_hi_stb, "R7 address",
                    32'({a_hi, a_mid, a_lo}), 32'(e.addr));
                chk({mem_rd, mem_wr, io_rd, io_wr} == es, "R6 strobes",
                    32'({mem_rd, mem_wr, io_rd, io_wr}), 32'(es));
                chk(tc == e.tc, "R5 tc", 32'(tc), 32'(e.tc));
                chk(mark == e.mk, "R11 mark", 32'(mark), 32'(e.mk));
            end
        end
    end

    task automatic finish_run();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R1 reset state
        chk(!hrq && dack == 0 && !mem_rd && !mem_wr && !io_rd && !io_wr && !tc && !mark && !a_hi_stb,
            "R1 outputs", 32'({hrq, dack}), 32'h0);
        reg_check(4'd8, 16'h0000, "R1 status");
        reg_check(4'd9, 16'h0000, "R1 mode");

        // R2 register readback
        reg_write(4'd2, 16'h1234);
        reg_write(4'd3, 16'h8005);
        reg_check(4'd2, 16'h1234, "R2 address");
        reg_check(4'd3, 16'h8005, "R2 count");

        // R4 request on disabled channel
        drq[1] = 1'b1;
        repeat (5) @(negedge clk);
        chk(!hrq && dack == 0, "R4 disabled request", 32'({hrq, dack}), 32'h0);
        drq[1] = 1'b0;

        // R3 R5 R6 R7 read block on channel 1, crossing a 256-byte boundary
        reg_write(4'd2, 16'h12FE);
        reg_write(4'd3, 16'h8003);
        reg_write(4'd8, 16'h0002);
        reg_check(4'd9, 16'h0002, "R2 mode");
        push_block(1, 16'h12FE, 4, 2);
        drq[1] = 1'b1;
        @(negedge clk);
        chk(hrq && dack == 0, "R3 hold before grant", 32'({hrq, dack}), 32'h10);
        drain();
        chk(!hrq, "R3 hold dropped", 32'(hrq), 32'h0);
        drq[1] = 1'b0;
        repeat (3) @(negedge clk);
        reg_check(4'd9, 16'h0000, "R5 enable cleared");
        reg_check(4'd8, 16'h0002, "R9 tc flag");
        reg_check(4'd8, 16'h0000, "R9 tc cleared by read");

        // R8 R6 simultaneous: verify on channel 0, write on channel 3
        reg_write(4'd0, 16'h0040);
        reg_write(4'd1, 16'h0001);
        reg_write(4'd6, 16'hABCD);
        reg_write(4'd7, 16'h4002);
        reg_write(4'd8, 16'h0009);
        push_block(0, 16'h0040, 2, 0);
        push_block(3, 16'hABCD, 3, 1);
        drq = 4'b1001;
        drain();
        drq = 4'b0000;
        repeat (3) @(negedge clk);
        reg_check(4'd8, 16'h0009, "R9 two tc flags");

        // R8 preemption in the middle of a channel 1 block
        reg_write(4'd2, 16'h0100);
        reg_write(4'd3, 16'h4004);
        reg_write(4'd0, 16'h0200);
        reg_write(4'd1, 16'h8001);
        reg_write(4'd8, 16'h0003);
        push_item(1, 16'h0100, 1, 1'b0, 1'b0);
        push_item(1, 16'h0101, 1, 1'b0, 1'b0);
        push_block(0, 16'h0200, 2, 2);
        push_item(1, 16'h0102, 1, 1'b0, 1'b0);
        push_item(1, 16'h0103, 1, 1'b0, 1'b0);
        push_item(1, 16'h0104, 1, 1'b1, 1'b0);
        drq[1] = 1'b1;
        begin
            int seen;
            seen = 0;
            while (seen < 2) begin
                @(negedge clk);
                if (dack[1]) seen++;
            end
        end
        drq[0] = 1'b1;
        drain();
        drq = 4'b0000;
        repeat (3) @(negedge clk);
        reg_check(4'd8, 16'h0003, "R8 both blocks finished");

        // R11 marker on the 128th transfer of a 130-transfer block
        reg_write(4'd0, 16'h2000);
        reg_write(4'd1, 16'h8081);
        reg_write(4'd8, 16'h0001);
        push_block(0, 16'h2000, 130, 2);
        drq[0] = 1'b1;
        drain();
        drq[0] = 1'b0;
        repeat (3) @(negedge clk);
        reg_check(4'd8, 16'h0001, "R11 block done");

        // R10 chaining: channel 2 reloads from channel 3
        reg_write(4'd6, 16'h5000);
        reg_write(4'd7, 16'h4002);
        reg_write(4'd4, 16'h4000);
        reg_write(4'd5, 16'h8001);
        reg_write(4'd8, 16'h0084);
        push_block(2, 16'h4000, 2, 2);
        push_block(2, 16'h5000, 3, 1);
        drq[2] = 1'b1;
        begin
            int seen;
            seen = 0;
            while (seen < 5) begin
                @(negedge clk);
                if (dack[2]) seen++;
            end
        end
        drq[2] = 1'b0;
        drain();
        reg_check(4'd8, 16'h0014, "R10 update flag and tc");
        reg_check(4'd8, 16'h0010, "R9 tc cleared, update kept");
        reg_check(4'd4, 16'h5000, "R10 reloaded address");
        reg_check(4'd5, 16'h4002, "R10 reloaded count");
        reg_check(4'd9, 16'h0084, "R10 channel stays enabled");
        chk(exp_q.size() == 0, "R5 all transfers seen", 32'(exp_q.size()), 32'h0);

        finish_run();
    end

endmodule